// File: doc/BRIEF.md
# 4x4 Hadamard DC Transform

This block gathers the sixteen DC coefficients of a 16x16 macroblock, one per 4x4 coefficient block, and applies a two-pass 4-point Hadamard transform to the 4x4 matrix they form. The first pass works on 32-bit sums and differences with no scaling. The second pass halves each result with rounding. Each result is then clamped into a signed 16-bit word.

DC words enter one at a time on a valid/ready stream. Each word carries the index of its 4x4 block, and the words may arrive in any order. The block indices count through the four 8x8 quadrants, with four blocks per quadrant, and the block places each word at its spatial row and column. When all sixteen distinct indices have been seen, the transform is latched. It then leaves as four rows of four values on a second valid/ready stream. A block index that arrives twice within one macroblock raises a flag. Quantisation of the results is left to the next stage.

Top module: `dc_hadamard4`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` and `err_dup` are 0 and `in_ready` is 1.
- R2: Block index bits b3..b0 place the DC word at matrix row {b3,b1} and column {b2,b0}. For example, index 4 lands at row 0, column 2.
- R3: Take the sequency-ordered Hadamard rows H0=(+,+,+,+), H1=(+,+,-,-), H2=(+,-,-,+) and H3=(+,-,+,-). Output (r,c) equals (S+1)>>1, using an arithmetic shift, where S = sum over i,j of Hr[i]*Hc[j]*D[i][j]. Each D[i][j] is a sign-extended 16-bit input.
- R4: A result above 32767 is output as 32767. A result below -32768 is output as -32768.
- R5: Results leave as four rows in order 0,1,2,3. `out_row` carries the row number, and column c sits in bits [16c+15:16c] of `out_data`.
- R6: No result is offered until all sixteen distinct block indices have been accepted. The arrival order does not matter.
- R7: Accepting an index already seen in the current macroblock sets `err_dup`, and the newer word replaces the older one. `err_dup` stays 1 until the last row of that macroblock is accepted.
- R8: `in_ready` is 0 from the moment the set is complete until its last row is accepted. While `out_ready` is 0, `out_valid`, `out_row` and `out_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | DC word present |
| in_ready | output | 1 | Block accepts a DC word |
| in_idx | input | 4 | Block index, quadrant-ordered |
| in_dc | input | 16 | Signed DC coefficient |
| out_valid | output | 1 | Result row present |
| out_ready | input | 1 | Consumer takes the row |
| out_row | output | 2 | Row number of `out_data` |
| out_data | output | 64 | Four signed 16-bit results, column 0 lowest |
| err_dup | output | 1 | Duplicate index seen in current macroblock |

## Verification
A wrong index-to-position mapping or a flipped butterfly sign corrupts specific result lanes. This shows on the first row that leaves after the sixteenth word, so single-block impulse frames localise it. A presence mask that loses or gains a bit shows up at once in one of two ways: the frame is released before the last word, or `in_ready` never falls and no rows appear. Both are caught by sampling `out_valid` just before the final word. A row counter or a hold register that moves under backpressure breaks the row order or the stability of the data within one stalled cycle.

// File: rtl/dch_pkg.sv
package dch_pkg;
    localparam int unsigned DC_W  = 16;
    localparam int unsigned ACC_W = 32;
    localparam int unsigned SIDE  = 4;
    localparam int unsigned NBLK  = SIDE * SIDE;
    localparam int unsigned IDX_W = $clog2(NBLK);
    localparam int unsigned POS_W = $clog2(SIDE);

    typedef logic signed [DC_W-1:0]  dc_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef dc_t     [SIDE-1:0] dc_row_t;
    typedef dc_row_t [SIDE-1:0] dc_mat_t;

    typedef struct packed {
        acc_t k3;
        acc_t k2;
        acc_t k1;
        acc_t k0;
    } quad_t;

    typedef struct packed {
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
    } pos_t;

    // quadrant-ordered index -> spatial position
    function automatic pos_t blk_pos(input logic [IDX_W-1:0] idx);
        pos_t p;
        p.row = {idx[3], idx[1]};
        p.col = {idx[2], idx[0]};
        return p;
    endfunction

    // 4-point Hadamard, sequency ordered, no scaling
    function automatic quad_t hbf4(input acc_t x0, input acc_t x1,
                                   input acc_t x2, input acc_t x3);
        acc_t  v0, v1, v2, v3;
        quad_t q;
        v0   = x0 + x1;
        v1   = x2 + x3;
        v2   = x0 - x1;
        v3   = x2 - x3;
        q.k0 = v0 + v1;
        q.k1 = v0 - v1;
        q.k2 = v2 - v3;
        q.k3 = v2 + v3;
        return q;
    endfunction

    function automatic acc_t half_rnd(input acc_t x);
        return (x + acc_t'(1)) >>> 1;
    endfunction

    function automatic dc_t sat_dc(input acc_t x);
        acc_t hi, lo;
        hi = (acc_t'(1) <<< (DC_W - 1)) - acc_t'(1);
        lo = -hi - acc_t'(1);
        if (x > hi)      return dc_t'(hi);
        else if (x < lo) return dc_t'(lo);
        else             return dc_t'(x);
    endfunction
endpackage

// File: rtl/dch_collect.sv
module dch_collect
    import dch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  dc_t              in_dc,
    input  logic             frame_done,
    output logic             in_ready,
    output logic             full,
    output logic             err_dup,
    output dc_mat_t          mat
);
    logic [NBLK-1:0] have;
    pos_t            p;
    logic            take;

    assign p        = blk_pos(in_idx);
    assign full     = &have;
    assign in_ready = ~full;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            have    <= '0;
            err_dup <= 1'b0;
            mat     <= '0;
        end else if (frame_done) begin
            have    <= '0;
            err_dup <= 1'b0;
        end else if (take) begin
            have[in_idx]      <= 1'b1;
            mat[p.row][p.col] <= in_dc;
            if (have[in_idx]) err_dup <= 1'b1;
        end
    end
endmodule

// File: rtl/dch_xform.sv
module dch_xform
    import dch_pkg::*;
(
    input  dc_mat_t mat,
    output dc_mat_t res
);
    acc_t colp [SIDE][SIDE];

    for (genvar j = 0; j < SIDE; j++) begin : g_vert
        quad_t q;
        assign q = hbf4(acc_t'($signed(mat[0][j])), acc_t'($signed(mat[1][j])),
                        acc_t'($signed(mat[2][j])), acc_t'($signed(mat[3][j])));
        assign colp[0][j] = q.k0;
        assign colp[1][j] = q.k1;
        assign colp[2][j] = q.k2;
        assign colp[3][j] = q.k3;
    end

    for (genvar r = 0; r < SIDE; r++) begin : g_horz
        quad_t h;
        assign h = hbf4(colp[r][0], colp[r][1], colp[r][2], colp[r][3]);
        assign res[r][0] = sat_dc(half_rnd(h.k0));
        assign res[r][1] = sat_dc(half_rnd(h.k1));
        assign res[r][2] = sat_dc(half_rnd(h.k2));
        assign res[r][3] = sat_dc(half_rnd(h.k3));
    end
endmodule

// File: rtl/dch_emit.sv
module dch_emit
    import dch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  dc_mat_t          res,
    input  logic             out_ready,
    output logic             busy,
    output logic             frame_done,
    output logic [POS_W-1:0] out_row,
    output dc_row_t          out_data
);
    localparam logic [POS_W-1:0] LAST = POS_W'(SIDE - 1);

    dc_mat_t hold;

    assign frame_done = busy & out_ready & (out_row == LAST);
    assign out_data   = hold[out_row];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            busy    <= 1'b0;
            out_row <= '0;
        end else if (load) begin
            hold    <= res;
            busy    <= 1'b1;
            out_row <= '0;
        end else if (busy && out_ready) begin
            if (out_row == LAST) busy <= 1'b0;
            else                 out_row <= out_row + 1'b1;
        end
    end
endmodule

// File: rtl/dc_hadamard4.sv
module dc_hadamard4
    import dch_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [IDX_W-1:0]       in_idx,
    input  logic [DC_W-1:0]        in_dc,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [POS_W-1:0]       out_row,
    output logic [SIDE*DC_W-1:0]   out_data,
    output logic                   err_dup
);
    dc_mat_t mat, res;
    dc_row_t row_data;
    logic    full, busy, frame_done;

    dch_collect u_collect (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
        .in_dc(dc_t'(in_dc)), .frame_done(frame_done), .in_ready(in_ready),
        .full(full), .err_dup(err_dup), .mat(mat)
    );

    dch_xform u_xform (.mat(mat), .res(res));

    dch_emit u_emit (
        .clk(clk), .rst(rst), .load(full & ~busy), .res(res),
        .out_ready(out_ready), .busy(busy), .frame_done(frame_done),
        .out_row(out_row), .out_data(row_data)
    );

    assign out_valid = busy;
    assign out_data  = row_data;
endmodule

// File: rtl/dc_hadamard4_chk.sv
module dc_hadamard4_chk
    import dch_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [POS_W-1:0]     out_row,
    input logic [SIDE*DC_W-1:0] out_data,
    input logic                 err_dup
);
    localparam logic [POS_W-1:0] LAST = POS_W'(SIDE - 1);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready && !err_dup));

    assert_first_row_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_row == '0);

    assert_row_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_row != LAST) |=> (out_valid && out_row == $past(out_row) + 1'b1));

    assert_release_after_full_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(!in_ready));

    assert_err_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_dup) |-> $past(in_valid && in_ready));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_dup && !(out_valid && out_ready && out_row == LAST)) |=> err_dup);

    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_data)));

    assert_no_input_while_out_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
endmodule

bind dc_hadamard4 dc_hadamard4_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_data(out_data), .err_dup(err_dup)
);

// File: tb/test_dc_hadamard4.sv
module test_dc_hadamard4;
    import dch_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [IDX_W-1:0]     in_idx = '0;
    logic [DC_W-1:0]      in_dc = '0;
    logic                 out_valid;
    logic                 out_ready;
    logic [POS_W-1:0]     out_row;
    logic [SIDE*DC_W-1:0] out_data;
    logic                 err_dup;

    int n_chk = 0;
    int n_err = 0;
    int rmode = 1;

    typedef struct {
        logic [63:0] data;
        logic        err;
        int          row;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    dc_hadamard4 i_dc_hadamard4 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_idx(in_idx), .in_dc(in_dc), .out_valid(out_valid),
        .out_ready(out_ready), .out_row(out_row), .out_data(out_data),
        .err_dup(err_dup)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int hv(input int k, input int n);
        case (k)
            0: return 1;
            1: return (n < 2) ? 1 : -1;
            2: return (n == 0 || n == 3) ? 1 : -1;
            default: return (n % 2 == 1) ? -1 : 1;
        endcase
    endfunction

    function automatic void model(input dc_t v[NBLK], output logic [63:0] rows[SIDE]);
        longint d[SIDE][SIDE];
        for (int i = 0; i < NBLK; i++) begin
            logic [3:0] b;
            b = i[3:0];
            d[{b[3], b[1]}][{b[2], b[0]}] = longint'(v[i]);
        end
        for (int r = 0; r < SIDE; r++) begin
            rows[r] = '0;
            for (int c = 0; c < SIDE; c++) begin
                longint s, y;
                s = 0;
                for (int i = 0; i < SIDE; i++)
                    for (int j = 0; j < SIDE; j++)
                        s += longint'(hv(r, i) * hv(c, j)) * d[i][j];
                y = (s + 1) >>> 1;
                if (y > 32767) y = 32767;
                if (y < -32768) y = -32768;
                rows[r][16*c +: 16] = y[15:0];
            end
        end
    endfunction

    task automatic push_item(input int idx, input dc_t val);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_idx   = idx[IDX_W-1:0];
        in_dc    = val;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // kind: 0 ascending, 1 descending, 2 stride-7 permutation
    task automatic send_frame(input dc_t v[NBLK], input int kind, input bit dup,
                              input string tag);
        logic [63:0] rows[SIDE];
        int ord[NBLK];
        model(v, rows);
        for (int r = 0; r < SIDE; r++) sb.push_back('{rows[r], dup, r, tag});
        for (int k = 0; k < NBLK; k++)
            ord[k] = (kind == 0) ? k : (kind == 1) ? (15 - k) : ((k * 7) % 16);
        if (dup) push_item(ord[0], 16'sh5A5A);
        for (int k = 0; k < NBLK - 1; k++) push_item(ord[k], v[ord[k]]);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R6", "valid before last word", {63'b0, out_valid}, 64'd0);
        chk(err_dup == dup, "R7", "flag before last word", {63'b0, err_dup}, {63'b0, dup});
        push_item(ord[NBLK-1], v[ord[NBLK-1]]);
    endtask

    // consumer ready pattern, changed just after the rising edge
    initial begin
        int cnt;
        cnt = 0;
        out_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            out_ready = (rmode == 1) ? 1'b1 : (rmode == 2) ? cnt[0] : 1'b0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6", "unexpected row", out_data, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_data == e.data, e.tag, "row data", out_data, e.data);
                chk(out_row == e.row[POS_W-1:0], "R5", "row order",
                    {62'b0, out_row}, 64'(e.row));
                chk(err_dup == e.err, "R7", "flag at output", {63'b0, err_dup}, {63'b0, e.err});
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R5 watchdog: actual=0 expected=1 (run did not complete)");
        finish_run();
    end

    initial begin
        dc_t v[NBLK];
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid in reset", {63'b0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid after reset", {63'b0, out_valid}, 64'd0);
        chk(in_ready == 1'b1, "R1", "ready after reset", {63'b0, in_ready}, 64'd1);
        chk(err_dup == 1'b0, "R1", "flag after reset", {63'b0, err_dup}, 64'd0);

        // R3 small ramp, ascending
        for (int i = 0; i < NBLK; i++) v[i] = dc_t'(i * 3 - 7);
        send_frame(v, 0, 1'b0, "R3");

        // R2 impulses reveal the position mapping
        for (int i = 0; i < NBLK; i++) v[i] = '0;
        v[4] = 16'sd100;
        send_frame(v, 0, 1'b0, "R2");
        for (int i = 0; i < NBLK; i++) v[i] = '0;
        v[9] = -16'sd51;
        send_frame(v, 1, 1'b0, "R2");

        // R3 wide signed values, descending order
        for (int i = 0; i < NBLK; i++) v[i] = dc_t'((i * 4111) % 65536 - 32768);
        send_frame(v, 1, 1'b0, "R3");

        // R4 positive, negative and mixed saturation
        for (int i = 0; i < NBLK; i++) v[i] = 16'sd32767;
        send_frame(v, 2, 1'b0, "R4");
        for (int i = 0; i < NBLK; i++) v[i] = -16'sd32768;
        send_frame(v, 0, 1'b0, "R4");
        for (int i = 0; i < NBLK; i++) v[i] = ((i[0] ^ i[1] ^ i[2] ^ i[3]) != 0) ? -16'sd32767 : 16'sd32767;
        send_frame(v, 1, 1'b0, "R4");

        // R7 duplicate with stalling consumer
        rmode = 2;
        for (int i = 0; i < NBLK; i++) v[i] = dc_t'(i * -100 + 3);
        send_frame(v, 2, 1'b1, "R7");

        // R8 backpressure
        while (sb.size() != 0) @(negedge clk);
        rmode = 0;
        for (int i = 0; i < NBLK; i++) v[i] = dc_t'(i * i - 40);
        send_frame(v, 2, 1'b0, "R8");
        repeat (6) @(negedge clk);
        chk(out_valid == 1'b1, "R8", "valid held", {63'b0, out_valid}, 64'd1);
        chk(in_ready == 1'b0, "R8", "input blocked", {63'b0, in_ready}, 64'd0);
        chk(out_data == sb[0].data, "R8", "data held", out_data, sb[0].data);
        repeat (3) @(negedge clk);
        chk(out_row == '0, "R8", "row held", {62'b0, out_row}, 64'd0);
        chk(out_data == sb[0].data, "R8", "data still held", out_data, sb[0].data);
        rmode = 1;

        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b1, "R8", "ready after last row", {63'b0, in_ready}, 64'd1);
        finish_run();
    end
endmodule